// File: doc/BRIEF.md
# SPI Master Byte Transfer Engine

This block drives one SPI burst at a time as bus master. Software-side logic writes a 32-bit control word that sets the clock mode, bit order, chip-select behaviour and receive handling. A one in the top bit of that word starts the burst. The burst length and the number of those bytes taken from the transmit queue are given as two separate 24-bit counts. Bytes beyond the transmit count go out as zero, so a long read needs only a few queued bytes.

The engine takes transmit bytes from a show-ahead FIFO through a pop strobe. It pushes each received byte to a receive FIFO unless the discard bit is set, which keeps write-only traffic out of the receive queue. The serial clock advances only on an external half-period strobe `sck_en`, so the clock divider lives outside the block. When the last byte has been shifted, the block raises a one-cycle completion pulse and the start bit reads back as zero again.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `ctrl_rdata` is zero, `sck` is low, every `cs_out` bit is low, and `tx_pop`, `rx_push` and `done` are low.
- R2: A write with bit 31 set while idle latches control bits 0, 1, 2, 4, 5, 6, 7, 8 and 12 and starts a burst. `ctrl_rdata` returns those bits, reads 0 in every other position, and reads bit 31 as 1 while busy. Bit 31 clears in the cycle `done` pulses. Control writes are ignored while busy.
- R3: The serial clock rests at the polarity bit (bit 1) whenever the engine is idle. With the phase bit (bit 0) clear, each bit is valid before the leading edge and is sampled on that edge. With bit 0 set, data changes on the leading edge and is sampled on the trailing edge.
- R4: Bit 12 set shifts every byte least significant bit first, on `mosi` and `miso` alike. With bit 12 clear, the most significant bit goes first.
- R5: The first min(tx_len, burst_len) bytes on `mosi` are popped transmit bytes, in order. Every later byte of the burst is 0x00.
- R6: If a byte is due from the transmit FIFO and `tx_empty` is high, `sck` makes no edge until a byte arrives.
- R7: Each byte received on `miso` is presented on `rx_data` with a one-cycle `rx_push` unless bit 8 is set. With bit 8 set, no push occurs.
- R8: `done` pulses for exactly one cycle per burst, after the last byte. A burst length of zero produces `done` with no clock edge and no pop.
- R9: In automatic mode (bit 6 clear), output number bits 5:4 is asserted from the cycle after start until the cycle after `done`. Every other output is held inactive. Bit 2 set makes the asserted level low; bit 2 clear makes it high.
- R10: In manual mode (bit 6 set), the selected output follows bit 7 directly, busy or not, and is never asserted automatically. Every other output is held inactive.
- R11: `tx_pop` pulses at most once per byte, only after `tx_empty` was low, and exactly min(tx_len, burst_len) times per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word to write |
| ctrl_rdata | output | 32 | Control readback, bit 31 = busy |
| burst_len | input | CNT_W | Total bytes in the burst |
| tx_len | input | CNT_W | Bytes taken from the transmit FIFO |
| sck_en | input | 1 | Half-period strobe for the serial clock |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | WORD_W | Head of the transmit FIFO (show-ahead) |
| tx_pop | output | 1 | Remove the head of the transmit FIFO |
| rx_push | output | 1 | Write `rx_data` to the receive FIFO |
| rx_data | output | WORD_W | Received byte |
| done | output | 1 | Burst complete pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | NUM_CS | Chip-select outputs |

## Verification
The assertions assume a FIFO that keeps `tx_data` valid whenever `tx_empty` is low and updates `tx_empty` only after a pop. They also assume the receive FIFO always has room. The bench keeps within both assumptions by modelling the transmit queue itself and removing the head only when it sees `tx_pop`. It drives `miso` from a slave model that changes only between sampling edges. `sck_en`, the control word and the counts change only at falling clock edges. The counts change only together with a start write, which matches the engine latching them at start.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_SHIFT,
    SEQ_FINISH
  } seq_state_t;

  // Latched configuration; field widths follow the control word layout
  typedef struct packed {
    logic       lsb_first;
    logic       discard;
    logic       cs_level;
    logic       cs_manual;
    logic [1:0] cs_idx;
    logic       cs_act_low;
    logic       cpol;
    logic       cpha;
  } xfer_cfg_t;

  localparam int BIT_CPHA    = 0;
  localparam int BIT_CPOL    = 1;
  localparam int BIT_CSLOW   = 2;
  localparam int BIT_CSIDX   = 4;
  localparam int BIT_MANUAL  = 6;
  localparam int BIT_LEVEL   = 7;
  localparam int BIT_DISCARD = 8;
  localparam int BIT_LSB     = 12;
  localparam int BIT_START   = 31;

  function automatic xfer_cfg_t cfg_from_word(input logic [31:0] w);
    xfer_cfg_t c;
    c.cpha       = w[BIT_CPHA];
    c.cpol       = w[BIT_CPOL];
    c.cs_act_low = w[BIT_CSLOW];
    c.cs_idx     = w[BIT_CSIDX+:2];
    c.cs_manual  = w[BIT_MANUAL];
    c.cs_level   = w[BIT_LEVEL];
    c.discard    = w[BIT_DISCARD];
    c.lsb_first  = w[BIT_LSB];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input xfer_cfg_t c, input logic busy);
    logic [31:0] w;
    w                = '0;
    w[BIT_CPHA]      = c.cpha;
    w[BIT_CPOL]      = c.cpol;
    w[BIT_CSLOW]     = c.cs_act_low;
    w[BIT_CSIDX+:2]  = c.cs_idx;
    w[BIT_MANUAL]    = c.cs_manual;
    w[BIT_LEVEL]     = c.cs_level;
    w[BIT_DISCARD]   = c.discard;
    w[BIT_LSB]       = c.lsb_first;
    w[BIT_START]     = busy;
    return w;
  endfunction

endpackage

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [1:0]        cs_idx,
  input  logic              cs_manual,
  input  logic              cs_level,
  input  logic              cs_act_low,
  output logic [NUM_CS-1:0] cs_out
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic sel;
    assign sel = (cs_idx == 2'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        cs_out[i] <= 1'b0;
      end else if (!sel) begin
        cs_out[i] <= cs_act_low;
      end else if (cs_manual) begin
        cs_out[i] <= cs_level;
      end else begin
        cs_out[i] <= busy ^ cs_act_low;
      end
    end
  end

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sck_en,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              miso,
  output logic              sck_raw,
  output logic              mosi,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word
);

  localparam int EDGES  = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int IDX_W  = $clog2(WORD_W);

  logic              active;
  logic [EDGE_W-1:0] edge_q;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic [WORD_W-1:0] rx_next;
  logic [IDX_W-1:0]  bit_k;
  logic              step;
  logic              sample_now;
  logic              last_edge;

  function automatic logic pick(input logic [WORD_W-1:0] w, input int k, input logic lsb);
    return lsb ? w[k] : w[WORD_W-1-k];
  endfunction

  assign bit_k      = edge_q[EDGE_W-1:1];
  assign step       = active && sck_en;
  assign sample_now = step && (edge_q[0] == cpha);
  assign last_edge  = (edge_q == EDGE_W'(EDGES - 1));

  always_comb begin
    rx_next = rx_q;
    if (sample_now) begin
      if (lsb_first) rx_next[int'(bit_k)] = miso;
      else           rx_next[WORD_W-1-int'(bit_k)] = miso;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      edge_q    <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      sck_raw   <= 1'b0;
      mosi      <= 1'b0;
      word_done <= 1'b0;
      rx_word   <= '0;
    end else begin
      word_done <= 1'b0;
      if (load) begin
        active <= 1'b1;
        edge_q <= '0;
        tx_q   <= load_word;
        rx_q   <= '0;
        if (!cpha) mosi <= pick(load_word, 0, lsb_first);
      end else if (step) begin
        sck_raw <= ~sck_raw;
        edge_q  <= edge_q + 1'b1;
        rx_q    <= rx_next;
        if (cpha && !edge_q[0])
          mosi <= pick(tx_q, int'(bit_k), lsb_first);
        if (!cpha && edge_q[0] && (bit_k != IDX_W'(WORD_W - 1)))
          mosi <= pick(tx_q, int'(bit_k) + 1, lsb_first);
        if (last_edge) begin
          active    <= 1'b0;
          word_done <= 1'b1;
          rx_word   <= rx_next;
        end
      end
    end
  end

endmodule

// File: rtl/spi_byte_sequencer.sv
module spi_byte_sequencer
  import spi_xfer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              word_done,
  output logic              load,
  output logic [WORD_W-1:0] load_word,
  output logic              tx_pop,
  output logic              done,
  output logic              busy
);

  seq_state_t       state;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] tx_left;

  assign busy = (state != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      remaining <= '0;
      tx_left   <= '0;
      load      <= 1'b0;
      load_word <= '0;
      tx_pop    <= 1'b0;
      done      <= 1'b0;
    end else begin
      load   <= 1'b0;
      tx_pop <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            remaining <= burst_len;
            tx_left   <= tx_len;
            state     <= (burst_len == '0) ? SEQ_FINISH : SEQ_FETCH;
          end
        end
        SEQ_FETCH: begin
          if (tx_left != '0) begin
            if (!tx_empty) begin
              load      <= 1'b1;
              load_word <= tx_data;
              tx_pop    <= 1'b1;
              tx_left   <= tx_left - 1'b1;
              state     <= SEQ_SHIFT;
            end
          end else begin
            load      <= 1'b1;
            load_word <= '0;
            state     <= SEQ_SHIFT;
          end
        end
        SEQ_SHIFT: begin
          if (word_done) begin
            remaining <= remaining - 1'b1;
            state     <= (remaining == CNT_W'(1)) ? SEQ_FINISH : SEQ_FETCH;
          end
        end
        SEQ_FINISH: begin
          done  <= 1'b1;
          state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int WORD_W = 8,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  output logic [31:0]       ctrl_rdata,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              sck_en,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_out
);

  xfer_cfg_t         cfg_q;
  logic              busy;
  logic              start;
  logic              load;
  logic [WORD_W-1:0] load_word;
  logic              word_done;
  logic [WORD_W-1:0] rx_word;
  logic              sck_raw;

  assign start = ctrl_wr && ctrl_wdata[BIT_START] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      if (ctrl_wr && !busy) cfg_q <= cfg_from_word(ctrl_wdata);
      rx_push <= word_done && !cfg_q.discard;
      if (word_done) rx_data <= rx_word;
    end
  end

  assign ctrl_rdata = cfg_to_word(cfg_q, busy);
  assign sck        = sck_raw ^ cfg_q.cpol;

  spi_byte_sequencer #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .burst_len (burst_len),
    .tx_len    (tx_len),
    .tx_empty  (tx_empty),
    .tx_data   (tx_data),
    .word_done (word_done),
    .load      (load),
    .load_word (load_word),
    .tx_pop    (tx_pop),
    .done      (done),
    .busy      (busy)
  );

  spi_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cpha      (cfg_q.cpha),
    .lsb_first (cfg_q.lsb_first),
    .sck_en    (sck_en),
    .load      (load),
    .load_word (load_word),
    .miso      (miso),
    .sck_raw   (sck_raw),
    .mosi      (mosi),
    .word_done (word_done),
    .rx_word   (rx_word)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cs_idx     (cfg_q.cs_idx),
    .cs_manual  (cfg_q.cs_manual),
    .cs_level   (cfg_q.cs_level),
    .cs_act_low (cfg_q.cs_act_low),
    .cs_out     (cs_out)
  );

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_wr,
  input logic [31:0] ctrl_wdata,
  input logic [31:0] ctrl_rdata,
  input logic        tx_empty,
  input logic        tx_pop,
  input logic        rx_push,
  input logic        done,
  input logic        sck
);

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rdata[31] |-> (sck == ctrl_rdata[1])); // R3

  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_rdata[31]) |-> $past(ctrl_wr && ctrl_wdata[31])); // R2

  AST_POP_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $past(!tx_empty)); // R11

  AST_POP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> ctrl_rdata[31]); // R11

  AST_DISCARD_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !ctrl_rdata[8]); // R7

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !ctrl_rdata[31]); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

endmodule

bind spi_xfer_engine spi_xfer_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_wr    (ctrl_wr),
  .ctrl_wdata (ctrl_wdata),
  .ctrl_rdata (ctrl_rdata),
  .tx_empty   (tx_empty),
  .tx_pop     (tx_pop),
  .rx_push    (rx_push),
  .done       (done),
  .sck        (sck)
);

// File: tb/spi_xfer_engine_test.sv
module spi_xfer_engine_test;

  localparam int WATCHDOG = 150000;
  localparam logic [31:0] CFG_MASK = 32'h0000_11F7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic [23:0] burst_len = '0;
  logic [23:0] tx_len = '0;
  logic        sck_en = 1'b0;
  logic        tx_empty = 1'b1;
  logic [7:0]  tx_data = '0;
  logic        tx_pop;
  logic        rx_push;
  logic [7:0]  rx_data;
  logic        done;
  logic        sck;
  logic        mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_out;

  always #10 clk = ~clk;

  spi_xfer_engine uut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .burst_len(burst_len), .tx_len(tx_len),
    .sck_en(sck_en), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .done(done), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_out(cs_out)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int pops = 0;
  int done_cnt = 0;
  int rx_cnt = 0;
  int edges = 0;
  int sb = 0;
  logic [7:0]  cap = '0;
  logic [31:0] cur_ctrl = '0;
  logic [31:0] prev_rd = '0;
  logic        sck_prev = 1'b0;

  logic [7:0] q_tx[$];
  logic [7:0] slave_q[$];
  logic [7:0] mosi_exp[$];
  logic [7:0] rx_exp[$];
  logic [7:0] tx_src[$];

  function automatic logic pick(input logic [7:0] w, input int k, input logic lsb);
    return lsb ? w[k] : w[7-k];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cs(input logic [31:0] r);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) begin
      if (r[5:4] != 2'(i))  v[i] = r[2];
      else if (r[6])        v[i] = r[7];
      else                  v[i] = r[31] ^ r[2];
    end
    return v;
  endfunction

  // Cycle-by-cycle monitor and environment models
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (rst) begin
      prev_rd  = '0;
      sck_prev = sck;
    end else begin
      if (tx_pop) begin
        if (q_tx.size() > 0) void'(q_tx.pop_front());
        pops++;
      end
      if (done) done_cnt++;
      if (rx_push) begin
        rx_cnt++;
        if (rx_exp.size() == 0) chk(1'b0, "R7", "unexpected rx push", {24'd0, rx_data}, 0);
        else begin
          logic [7:0] e;
          e = rx_exp.pop_front();
          chk(rx_data == e, "R7", "rx byte", {24'd0, rx_data}, {24'd0, e});
        end
      end
      if (ctrl_rdata[31] && prev_rd[31] && (sck != sck_prev)) begin
        logic lead;
        edges++;
        lead = (sck_prev == cur_ctrl[1]);
        if (lead != cur_ctrl[0]) begin
          if (cur_ctrl[12]) cap[sb] = mosi; else cap[7-sb] = mosi;
          sb++;
          if (sb == 8) begin
            if (mosi_exp.size() == 0) chk(1'b0, "R5", "extra mosi byte", {24'd0, cap}, 0);
            else begin
              logic [7:0] e;
              e = mosi_exp.pop_front();
              chk(cap == e, "R4", "mosi byte order/value (R5)", {24'd0, cap}, {24'd0, e});
            end
            if (slave_q.size() > 0) void'(slave_q.pop_front());
            sb = 0;
          end
        end
      end
      chk(cs_out == exp_cs(prev_rd), prev_rd[6] ? "R10" : "R9", "chip select",
          {28'd0, cs_out}, {28'd0, exp_cs(prev_rd)});
      if (!ctrl_rdata[31])
        chk(sck == ctrl_rdata[1], "R3", "idle sck level", {31'd0, sck}, {31'd0, ctrl_rdata[1]});
      prev_rd  = ctrl_rdata;
      sck_prev = sck;
    end
    tx_empty = (q_tx.size() == 0);
    tx_data  = (q_tx.size() > 0) ? q_tx[0] : 8'h00;
    miso     = (slave_q.size() > 0) ? pick(slave_q[0], sb, cur_ctrl[12]) : 1'b0;
    sck_en   = (cyc % 3 == 0);
  end

  task automatic launch(input logic [31:0] ctrl, input int burst, input int xmit, input int npre);
    int nx;
    nx = (xmit < burst) ? xmit : burst;
    mosi_exp.delete(); rx_exp.delete(); slave_q.delete();
    for (int i = 0; i < burst; i++) begin
      logic [7:0] s;
      s = 8'hA5 ^ 8'(i * 37);
      mosi_exp.push_back((i < nx) ? tx_src[i] : 8'h00);
      slave_q.push_back(s);
      if (!ctrl[8]) rx_exp.push_back(s);
    end
    for (int i = 0; i < npre; i++) q_tx.push_back(tx_src[i]);
    cur_ctrl = ctrl & CFG_MASK;
    pops = 0;
    sb = 0;
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = ctrl | 32'h8000_0000;
    burst_len = 24'(burst); tx_len = 24'(xmit);
    @(negedge clk);
    ctrl_wr = 1'b0;
    #1;
    chk(ctrl_rdata == (cur_ctrl | 32'h8000_0000), "R2", "readback while busy",
        ctrl_rdata, cur_ctrl | 32'h8000_0000);
  endtask

  task automatic finish_xfer(input int exp_pops, input int d0);
    while (done_cnt == d0) @(negedge clk);
    #1;
    chk(ctrl_rdata[31] == 1'b0, "R2", "busy clear at done", ctrl_rdata, cur_ctrl);
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(done_cnt == d0 + 1, "R8", "single done pulse", done_cnt, d0 + 1);
    chk(mosi_exp.size() == 0, "R5", "all bytes shifted", mosi_exp.size(), 0);
    chk(rx_exp.size() == 0, "R7", "all rx pushed", rx_exp.size(), 0);
    chk(pops == exp_pops, "R11", "pop count", pops, exp_pops);
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  initial begin
    int d0;
    int e0;
    int r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(ctrl_rdata == 0, "R1", "reset readback", ctrl_rdata, 0);
    chk(cs_out == 0 && sck == 0, "R1", "reset cs/sck", {27'd0, sck, cs_out}, 0);
    chk(!tx_pop && !rx_push && !done, "R1", "reset strobes", {29'd0, tx_pop, rx_push, done}, 0);

    // Mode 0, MSB first, cs 1, all bytes from FIFO
    tx_src = '{8'h3C, 8'h81, 8'hF0};
    d0 = done_cnt;
    launch(32'h0000_0010, 3, 3, 3);
    finish_xfer(3, d0);

    // Mode 3, LSB first, cs 0, zero fill after two bytes
    tx_src = '{8'hA6, 8'h17};
    d0 = done_cnt;
    launch(32'h0000_1003, 4, 2, 2);
    finish_xfer(2, d0);

    // Mode 1, active-low cs 3, receive discard
    tx_src = '{8'h55, 8'hC8};
    d0 = done_cnt; r0 = rx_cnt;
    launch(32'h0000_0135, 2, 2, 2);
    finish_xfer(2, d0);
    chk(rx_cnt == r0, "R7", "discard suppresses pushes", rx_cnt - r0, 0);

    // Mode 2, stall on empty FIFO
    tx_src = '{8'h5A, 8'hC3};
    d0 = done_cnt; r0 = rx_cnt;
    launch(32'h0000_0022, 2, 2, 1);
    while (rx_cnt == r0) @(negedge clk);
    e0 = edges;
    repeat (60) @(negedge clk);
    #1;
    chk(edges == e0, "R6", "no sck edges while starved", edges - e0, 0);
    chk(sck == 1'b1 && ctrl_rdata[31], "R6", "sck idle and busy while starved",
        {30'd0, sck, ctrl_rdata[31]}, 3);
    q_tx.push_back(8'hC3);
    finish_xfer(2, d0);

    // Control writes ignored while busy
    tx_src = '{8'h99, 8'h66};
    d0 = done_cnt;
    launch(32'h0000_0000, 2, 2, 2);
    repeat (10) @(negedge clk);
    write_ctrl(32'h8000_1107);
    #1;
    chk(ctrl_rdata == 32'h8000_0000, "R2", "write during busy ignored", ctrl_rdata, 32'h8000_0000);
    finish_xfer(2, d0);

    // Transmit count larger than burst
    tx_src = '{8'hE1, 8'h22, 8'h33};
    d0 = done_cnt;
    launch(32'h0000_0000, 1, 3, 1);
    finish_xfer(1, d0);

    // Zero-length burst
    tx_src = '{8'h11, 8'h22};
    d0 = done_cnt; e0 = edges;
    launch(32'h0000_0000, 0, 2, 2);
    finish_xfer(0, d0);
    chk(edges == e0, "R8", "no edges for empty burst", edges - e0, 0);
    q_tx.delete();
    @(negedge clk);

    // Manual chip select
    write_ctrl(32'h0000_00E0);
    @(negedge clk);
    #1;
    chk(cs_out == 4'b0100, "R10", "manual level high on cs 2", {28'd0, cs_out}, 4);
    tx_src = '{8'h7E};
    d0 = done_cnt;
    launch(32'h0000_0074, 1, 1, 1);
    repeat (8) @(negedge clk);
    #1;
    chk(cs_out == 4'b0111, "R10", "manual level held during burst", {28'd0, cs_out}, 7);
    finish_xfer(1, d0);
    #1;
    chk(cs_out == 4'b0111, "R10", "manual level after burst", {28'd0, cs_out}, 7);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule